// File: doc/BRIEF.md
# Adaptive Minimum On-Time Blanking Timer

This block belongs to one channel of a synchronous-rectifier controller. It times how long the rectifier conducted in the previous switching cycle. Conduction starts at the rising edge of the gate-on request and ends when the drain-high comparator asserts. From that measurement it derives a blanking interval for the next cycle, and during that interval the turn-off comparator is ignored. The interval is a fraction of the measured time: one half in normal mode and roughly one fifth when the delay-mode flag is set. It is then clamped between a floor and a mode-dependent ceiling.

The blanking window also serves as the observation window for a debounced current-inversion detector. A long enough run of the inversion comparator inside the window forces the gate off at once. It also raises a flag that tells the turn-on logic to apply its longer delay at the next turn-on. A hard on-time limit forces the gate off independently of all comparators. All times are counted in clock ticks and set by parameters. The defaults assume a 100 MHz clock: a 200 ns floor, a 5 µs or 2.5 µs ceiling, a 320 ns debounce and a 30 µs maximum on-time.

Top module: `sr_blank_timer`

## Requirements
- R1: While reset is held low, `gate_off_o`, `blank_o` and `inv_det_o` are all low.
- R2: The conduction time of a cycle is the number of clock edges from the first edge that samples `gate_on_i` high (the first counted edge) up to, but not including, the first edge that samples `drain_hi_i` high. It becomes the basis for the blanking length of the following gate-on period.
- R3: With `dly_mode_i` low while the gate is off, the blanking length B is floor(T/2), where T is the last measured conduction time.
- R4: With `dly_mode_i` high while the gate is off, B is floor(13·T/64).
- R5: B is never below MIN_BLANK ticks.
- R6: B is never above MAX_BLANK_NORM ticks in normal mode, nor above MAX_BLANK_DLY ticks in delay mode.
- R7: Until the first conduction measurement after reset has completed, B equals MIN_BLANK.
- R8: Let n be the number of clock edges since `gate_on_i` rose. While the gate is on, `blank_o` is high exactly for n < B. During that time `toff_cmp_i` has no effect on `gate_off_o`. Once n ≥ B, `gate_off_o` follows `toff_cmp_i` in the same cycle.
- R9: Suppose `inv_cmp_i` is sampled high on INV_DEBOUNCE consecutive edges that all fall inside the blanking window of one gate-on period. Then `gate_off_o` goes high after the last of those edges and stays high until `gate_on_i` falls. A shorter run, or a run broken by the end of the window, has no effect.
- R10: `inv_det_o` rises one edge after an inversion trip. It stays high through the gate-off time and is cleared at the first edge of the next gate-on period.
- R11: Once n reaches MAX_ON, `gate_off_o` is high for as long as `gate_on_i` stays high.
- R12: `blank_o` and `gate_off_o` are low whenever `gate_on_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_on_i | input | 1 | Gate-on request from the turn-on logic |
| toff_cmp_i | input | 1 | Turn-off comparator output |
| drain_hi_i | input | 1 | Drain-high comparator output, ends conduction measurement |
| inv_cmp_i | input | 1 | Current-inversion comparator output |
| dly_mode_i | input | 1 | Delay-mode flag, selects the 20 % ratio and lower ceiling |
| gate_off_o | output | 1 | Gate-off command |
| blank_o | output | 1 | Blanking window active |
| inv_det_o | output | 1 | Current inversion detected in the last gate-on period |

## Verification
The bench builds the block with MIN_BLANK=4, MAX_BLANK_NORM=40, MAX_BLANK_DLY=20, INV_DEBOUNCE=6 and MAX_ON=150, with a 12-bit counter. At these sizes a few hundred cycles reach both ceilings, the floor and the 30 %-of-window inversion runs. They also reach a run cut off by the end of the window and the forced turn-off at the on-time limit. The shift-and-add form of the 13/64 ratio is the variant selected.

// File: rtl/sr_blank_pkg.sv
package sr_blank_pkg;

   typedef enum logic {
      RATIO_HALF  = 1'b0,
      RATIO_FIFTH = 1'b1
   } ratio_e;

   function automatic int clamp_int(input int v, input int lo, input int hi);
      int r;
      r = v;
      if (r > hi) r = hi;
      if (r < lo) r = lo;
      return r;
   endfunction

endpackage

// File: rtl/sr_cond_meter.sv
module sr_cond_meter #(
   parameter int CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_i,
   input  logic             drain_hi_i,
   output logic [CNT_W-1:0] cond_o,
   output logic             valid_o
);
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   logic             run_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         cnt_q   <= '0;
         cond_o  <= '0;
         valid_o <= 1'b0;
      end else if (rise_i) begin
         run_q <= 1'b1;
         cnt_q <= CNT_W'(1);
      end else if (run_q) begin
         if (drain_hi_i) begin
            cond_o  <= cnt_q;
            valid_o <= 1'b1;
            run_q   <= 1'b0;
         end else if (cnt_q != CNT_TOP) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/sr_blank_calc.sv
module sr_blank_calc
   import sr_blank_pkg::*;
#(
   parameter int CNT_W          = 13,
   parameter int MIN_BLANK      = 20,
   parameter int MAX_BLANK_NORM = 500,
   parameter int MAX_BLANK_DLY  = 250,
   parameter bit USE_SHIFT_ADD  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cond_i,
   input  logic             valid_i,
   input  logic             dly_mode_i,
   input  logic             hold_i,
   output logic [CNT_W-1:0] blank_len_o
);
   localparam int PROD_W = CNT_W + 4;

   ratio_e            ratio;
   logic [PROD_W-1:0] wide;
   logic [PROD_W-1:0] prod13;
   logic [CNT_W-1:0]  half_v;
   logic [CNT_W-1:0]  fifth_v;
   logic [CNT_W-1:0]  raw_v;
   logic [CNT_W-1:0]  next_len;

   assign ratio = dly_mode_i ? RATIO_FIFTH : RATIO_HALF;
   assign wide  = {4'b0000, cond_i};

   generate
      if (USE_SHIFT_ADD) begin : g_shadd
         assign prod13 = (wide << 3) + (wide << 2) + wide;
      end else begin : g_mult
         assign prod13 = wide * PROD_W'(13);
      end
   endgenerate

   assign half_v  = cond_i >> 1;
   assign fifth_v = CNT_W'(prod13 >> 6);
   assign raw_v   = (ratio == RATIO_FIFTH) ? fifth_v : half_v;

   always_comb begin
      if (!valid_i) begin
         next_len = CNT_W'(MIN_BLANK);
      end else if (ratio == RATIO_FIFTH) begin
         next_len = CNT_W'(clamp_int(int'(raw_v), MIN_BLANK, MAX_BLANK_DLY));
      end else begin
         next_len = CNT_W'(clamp_int(int'(raw_v), MIN_BLANK, MAX_BLANK_NORM));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        blank_len_o <= CNT_W'(MIN_BLANK);
      else if (!hold_i)  blank_len_o <= next_len;
   end

endmodule

// File: rtl/sr_on_window.sv
module sr_on_window #(
   parameter int CNT_W        = 13,
   parameter int INV_DEBOUNCE = 32,
   parameter int MAX_ON       = 3000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate_on_i,
   input  logic             inv_cmp_i,
   input  logic [CNT_W-1:0] blank_len_i,
   output logic             blank_o,
   output logic             trip_o,
   output logic             max_hit_o
);
   localparam int DEB_W = $clog2(INV_DEBOUNCE + 1);
   localparam logic [CNT_W-1:0] ON_LIMIT = CNT_W'(MAX_ON);
   localparam logic [DEB_W-1:0] DEB_LIM  = DEB_W'(INV_DEBOUNCE);

   logic [CNT_W-1:0] on_cnt_q;
   logic [DEB_W-1:0] deb_q;

   assign blank_o   = gate_on_i && (on_cnt_q < blank_len_i);
   assign trip_o    = (deb_q == DEB_LIM);
   assign max_hit_o = gate_on_i && (on_cnt_q >= ON_LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  on_cnt_q <= '0;
      else if (!gate_on_i)         on_cnt_q <= '0;
      else if (on_cnt_q < ON_LIMIT) on_cnt_q <= on_cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    deb_q <= '0;
      else if (!gate_on_i)           deb_q <= '0;
      else if (trip_o)               deb_q <= deb_q;
      else if (blank_o && inv_cmp_i) deb_q <= deb_q + DEB_W'(1);
      else                           deb_q <= '0;
   end

endmodule

// File: rtl/sr_blank_timer.sv
module sr_blank_timer #(
   parameter int CNT_W          = 13,
   parameter int MIN_BLANK      = 20,
   parameter int MAX_BLANK_NORM = 500,
   parameter int MAX_BLANK_DLY  = 250,
   parameter int INV_DEBOUNCE   = 32,
   parameter int MAX_ON         = 3000,
   parameter bit USE_SHIFT_ADD  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_on_i,
   input  logic toff_cmp_i,
   input  logic drain_hi_i,
   input  logic inv_cmp_i,
   input  logic dly_mode_i,
   output logic gate_off_o,
   output logic blank_o,
   output logic inv_det_o
);
   generate
      if (MIN_BLANK < 1 || MIN_BLANK > MAX_BLANK_DLY) begin : g_bad_floor
         $error("MIN_BLANK must be at least 1 and not above MAX_BLANK_DLY");
      end
      if (MAX_BLANK_DLY > MAX_BLANK_NORM) begin : g_bad_ceil
         $error("MAX_BLANK_DLY must not exceed MAX_BLANK_NORM");
      end
      if (MAX_BLANK_NORM >= MAX_ON) begin : g_bad_maxon
         $error("MAX_ON must exceed MAX_BLANK_NORM");
      end
      if (MAX_ON >= (1 << CNT_W) - 1) begin : g_bad_width
         $error("CNT_W too narrow for MAX_ON");
      end
      if (INV_DEBOUNCE < 1) begin : g_bad_deb
         $error("INV_DEBOUNCE must be at least 1");
      end
   endgenerate

   logic             gate_on_q;
   logic             rise;
   logic [CNT_W-1:0] cond_len;
   logic             cond_valid;
   logic [CNT_W-1:0] blank_len;
   logic             in_blank;
   logic             trip;
   logic             max_hit;
   logic             inv_flag_q;

   assign rise = gate_on_i && !gate_on_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_on_q <= 1'b0;
      else        gate_on_q <= gate_on_i;
   end

   sr_cond_meter #(.CNT_W(CNT_W)) u_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise_i     (rise),
      .drain_hi_i (drain_hi_i),
      .cond_o     (cond_len),
      .valid_o    (cond_valid)
   );

   sr_blank_calc #(
      .CNT_W          (CNT_W),
      .MIN_BLANK      (MIN_BLANK),
      .MAX_BLANK_NORM (MAX_BLANK_NORM),
      .MAX_BLANK_DLY  (MAX_BLANK_DLY),
      .USE_SHIFT_ADD  (USE_SHIFT_ADD)
   ) u_calc (
      .clk         (clk),
      .rst_n       (rst_n),
      .cond_i      (cond_len),
      .valid_i     (cond_valid),
      .dly_mode_i  (dly_mode_i),
      .hold_i      (gate_on_i),
      .blank_len_o (blank_len)
   );

   sr_on_window #(
      .CNT_W        (CNT_W),
      .INV_DEBOUNCE (INV_DEBOUNCE),
      .MAX_ON       (MAX_ON)
   ) u_window (
      .clk         (clk),
      .rst_n       (rst_n),
      .gate_on_i   (gate_on_i),
      .inv_cmp_i   (inv_cmp_i),
      .blank_len_i (blank_len),
      .blank_o     (in_blank),
      .trip_o      (trip),
      .max_hit_o   (max_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    inv_flag_q <= 1'b0;
      else if (trip) inv_flag_q <= 1'b1;
      else if (rise) inv_flag_q <= 1'b0;
   end

   assign blank_o    = in_blank;
   assign inv_det_o  = inv_flag_q;
   assign gate_off_o = gate_on_i && ((toff_cmp_i && !in_blank) || trip || max_hit);

endmodule

// File: rtl/sr_blank_timer_chk.sv
module sr_blank_timer_chk #(
   parameter int MIN_BLANK      = 20,
   parameter int MAX_BLANK_NORM = 500,
   parameter int MAX_ON         = 3000
) (
   input logic clk,
   input logic rst_n,
   input logic gate_on_i,
   input logic toff_cmp_i,
   input logic gate_off_o,
   input logic blank_o,
   input logic inv_det_o
);
   logic [31:0] on_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 on_len <= '0;
      else if (!gate_on_i)        on_len <= '0;
      else if (on_len < 32'(MAX_ON)) on_len <= on_len + 32'd1;
   end

   assert_blank_only_when_on_R12: assert property (@(posedge clk) disable iff (!rst_n)
      blank_o |-> gate_on_i);

   assert_floor_blanked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_on_i && on_len < 32'(MIN_BLANK)) |-> blank_o);

   assert_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_on_i && on_len >= 32'(MAX_BLANK_NORM)) |-> !blank_o);

   assert_toff_after_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_on_i && !blank_o && toff_cmp_i) |-> gate_off_o);

   assert_max_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_on_i && on_len >= 32'(MAX_ON)) |-> gate_off_o);

   assert_flag_needs_trip_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inv_det_o) |-> $past(gate_off_o && gate_on_i));

   assert_flag_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_on_i) |=> !inv_det_o);

endmodule

bind sr_blank_timer sr_blank_timer_chk #(
   .MIN_BLANK      (MIN_BLANK),
   .MAX_BLANK_NORM (MAX_BLANK_NORM),
   .MAX_ON         (MAX_ON)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .gate_on_i  (gate_on_i),
   .toff_cmp_i (toff_cmp_i),
   .gate_off_o (gate_off_o),
   .blank_o    (blank_o),
   .inv_det_o  (inv_det_o)
);

// File: tb/sr_blank_timer_tb.sv
module sr_blank_timer_tb;
   localparam int P_MIN  = 4;
   localparam int P_NORM = 40;
   localparam int P_DLY  = 20;
   localparam int P_DEB  = 6;
   localparam int P_MAX  = 150;

   typedef struct {
      int    cyc;
      bit    go;
      bit    bl;
      bit    det;
      string rgo;
      string rbl;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gate_on_i = 1'b0, toff_cmp_i = 1'b0, drain_hi_i = 1'b0;
   logic inv_cmp_i = 1'b0, dly_mode_i = 1'b0;
   logic gate_off_o, blank_o, inv_det_o;

   int    cyc = 0;
   int    total = 0;
   int    bad = 0;
   bit    finished = 1'b0;
   item_t q[$];

   bit    have_prev = 1'b0;
   int    prev_cond = 0;
   bit    det_m = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sr_blank_timer #(
      .CNT_W(12), .MIN_BLANK(P_MIN), .MAX_BLANK_NORM(P_NORM),
      .MAX_BLANK_DLY(P_DLY), .INV_DEBOUNCE(P_DEB), .MAX_ON(P_MAX),
      .USE_SHIFT_ADD(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .gate_on_i(gate_on_i), .toff_cmp_i(toff_cmp_i),
      .drain_hi_i(drain_hi_i), .inv_cmp_i(inv_cmp_i), .dly_mode_i(dly_mode_i),
      .gate_off_o(gate_off_o), .blank_o(blank_o), .inv_det_o(inv_det_o)
   );

   task automatic push(bit go, bit bl, bit det, string rgo, string rbl);
      item_t it;
      it.cyc = cyc; it.go = go; it.bl = bl; it.det = det;
      it.rgo = rgo; it.rbl = rbl;
      q.push_back(it);
   endtask

   task automatic cmp(string req, string what, bit act, bit exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", req, what, cyc, act, exp);
      end
   endtask

   // monitor: pops expected items and compares them mid low phase
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0 && q[0].cyc == cyc) begin
            item_t it;
            it = q.pop_front();
            cmp(it.rgo, "gate_off_o", gate_off_o, it.go);
            cmp(it.rbl, "blank_o", blank_o, it.bl);
            cmp("R10", "inv_det_o", inv_det_o, it.det);
         end
      end
   end

   function automatic int exp_blank(bit dly);
      int raw, lim;
      if (!have_prev) return P_MIN;                      // R7
      raw = dly ? (prev_cond * 13) / 64 : prev_cond / 2; // R3 / R4
      lim = dly ? P_DLY : P_NORM;                        // R6
      if (raw > lim) raw = lim;
      if (raw < P_MIN) raw = P_MIN;                      // R5
      return raw;
   endfunction

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         gate_on_i = 1'b0; toff_cmp_i = 1'b0; inv_cmp_i = 1'b0; drain_hi_i = 1'b0;
         push(1'b0, 1'b0, det_m, "R12", "R12");
      end
   endtask

   // driver: one gate-on period plus the tail of its conduction measurement
   task automatic pulse(int len, int cond_len, bit dly, int toff_from,
                        int inv_from, int inv_to, string breq);
      int b, icnt, span;
      @(negedge clk);
      dly_mode_i = dly;
      push(1'b0, 1'b0, det_m, "R12", "R12");
      idle(3);
      b = exp_blank(dly);
      icnt = 0;
      span = (len > cond_len ? len : cond_len) + 1;
      for (int k = 0; k < span; k++) begin
         bit g, tf, iv, bl, go, trip_m;
         @(negedge clk);
         g  = (k < len);
         tf = (toff_from >= 0) && (k >= toff_from);
         iv = (k >= inv_from) && (k < inv_to);
         gate_on_i  = g;
         toff_cmp_i = tf;
         inv_cmp_i  = iv;
         drain_hi_i = (k >= cond_len);
         trip_m = (icnt == P_DEB);
         bl = g && (k < b);
         go = g && ((tf && !bl) || trip_m || (k >= P_MAX));
         push(go, bl, det_m,
              trip_m ? "R9" : ((k >= P_MAX) ? "R11" : "R8"),
              g ? breq : "R12");
         if (trip_m)              det_m = 1'b1;
         else if (g && k == 0)    det_m = 1'b0;
         if (!g)                  icnt = 0;
         else if (trip_m)         icnt = icnt;
         else if (bl && iv)       icnt = icnt + 1;
         else                     icnt = 0;
      end
      prev_cond = cond_len;
      have_prev = 1'b1;
      idle(2);
   endtask

   initial begin
      // R1: outputs during reset
      repeat (3) begin
         @(negedge clk);
         push(1'b0, 1'b0, 1'b0, "R1", "R1");
      end
      @(negedge clk);
      rst_n = 1'b1;
      push(1'b0, 1'b0, 1'b0, "R1", "R1");

      pulse(10, 12, 1'b0, 2, 99, 99, "R7");          // no history: floor
      pulse(12, 30, 1'b0, 3, 99, 99, "R2 R3");       // 12/2 = 6
      pulse(20, 40, 1'b1, 1, 99, 99, "R2 R4");       // 30*13/64 = 6
      pulse(15, 100, 1'b1, -1, 99, 99, "R4");        // 40*13/64 = 8
      pulse(45, 200, 1'b0, 0, 99, 99, "R6");         // 50 -> 40
      pulse(25, 6, 1'b1, 0, 99, 99, "R6");           // 40 -> 20
      pulse(8, 10, 1'b0, 0, 99, 99, "R5");           // 3 -> 4
      pulse(12, 90, 1'b0, -1, 0, 4, "R9");           // short run, no trip
      pulse(20, 80, 1'b0, -1, 2, 30, "R9");          // trip, flag set
      pulse(50, 160, 1'b0, -1, 37, 50, "R10");       // run cut by window end
      pulse(160, 170, 1'b0, -1, 99, 99, "R11");      // on-time limit
      idle(4);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule